// File: doc/BRIEF.md
# Strap-Latched Configuration and Test-Clock Divider

This block owns four dual-use pins of a clock generator. While power-on reset is held low, the pins are inputs. Board resistors pull each one high or low, and the block captures their levels into a 4-bit configuration register. One bit selects the bus mode: synchronous, where the bus runs at half the CPU clock, or asynchronous. The other three bits form a frequency-select code. Once reset is released, the block enables the output drivers of the same pins, and from then on the pins carry clocks.

The frequency-select code has one value reserved for production test. When that code is latched, the block derives every clock itself from the reference clock:

- The REF output is the reference clock passed straight through.
- The CPU outputs and the 48 MHz output run at half the reference.
- The 24 MHz output runs at a quarter of the reference.
- The bus outputs run at a quarter of the reference in synchronous mode, and at a third in asynchronous mode.

For any other code, all test clocks stay low, and each shared pin carries the normal-mode clock supplied from outside this block. The pad cell is assumed to hold an undriven strap pin at logic 1 through its pull-up, so `pad_in` always arrives as a defined level.

Top module: `strap_tclk_gen`

## Requirements
- R1: On every rising `clk_ref` edge with `por_n` low, the block samples `pad_in`. The sample taken at the last such edge is the latched code. `pad_in[0]` becomes `o_bus_sync` (1 = synchronous bus), and `pad_in[3:1]` becomes `o_fsel[2:0]`.
- R2: After `por_n` goes high, changes on `pad_in` leave `o_bus_sync` and `o_fsel` unchanged until `por_n` is low again.
- R3: `pad_oe` is all zeros through the whole reset period and in the half cycle after release. It is all ones from the first rising edge sampled with `por_n` high.
- R4: `o_test_mode` is 1 exactly when `o_fsel` equals 3'b011, that is fs0=1, fs1=1 and fs2=0.
- R5: In test mode, once `pad_oe` is high, `o_ref_clk` equals `clk_ref`. Otherwise `o_ref_clk` is 0.
- R6: In test mode, every `o_cpu_clk` bit and `o_clk48` run at REF/2. Counting rising edges n after release, they are high exactly when n is odd, so they are low at release.
- R7: In test mode, `o_clk24` runs at REF/4. It is high exactly when n mod 4 is 2 or 3.
- R8: In test mode, every `o_bus_clk` bit equals `o_clk24` when `o_bus_sync`=1. When `o_bus_sync`=0 it runs at REF/3: high for one reference period, exactly when n is a nonzero multiple of 3, and low for two.
- R9: Outside test mode, `o_cpu_clk`, `o_bus_clk`, `o_clk48`, `o_clk24` and `o_ref_clk` stay 0, and `pad_out` equals `norm_pad_clk` bit for bit.
- R10: In test mode, `pad_out[0]` carries the REF test clock, `pad_out[1]` and `pad_out[2]` carry the CPU test clock, and `pad_out[3]` carries the bus test clock.
- R11: A rising edge sampled with `por_n` low forces every divided clock output to 0, `pad_oe` to 0 and `o_ref_clk` to 0 from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| pad_in | input | 4 | Levels on the shared pins (bit 0 bus mode, bits 3:1 frequency select) |
| norm_pad_clk | input | 4 | Normal-mode clocks for the shared pins |
| pad_out | output | 4 | Data driven onto the shared pins |
| pad_oe | output | 4 | Output enables of the shared pins |
| o_bus_sync | output | 1 | Latched bus-mode bit |
| o_fsel | output | 3 | Latched frequency-select code |
| o_test_mode | output | 1 | Latched code is the test code |
| o_ref_clk | output | 1 | Test REF clock |
| o_cpu_clk | output | N_CPU | Test CPU clocks |
| o_bus_clk | output | N_BUS | Test bus clocks |
| o_clk48 | output | 1 | Test copy of the 48 MHz output |
| o_clk24 | output | 1 | Test copy of the 24 MHz output |

## Verification
The main function is tried with seven strap patterns:

- Both test-code patterns, one per bus mode. These separate the REF/4 bus clock from the REF/3 bus clock.
- Three codes one bit away from the test code (fs2 set, fs1 clear, fs0 clear). These show that the decode matches all three select bits, not a subset.
- The all-ones code, which is what unconnected pins would give, and the all-zeros code. These show the idle behaviour and that the normal-mode clocks pass through to the pads.

Each pattern is held through reset and then inverted on the pins after release. This tells real capture apart from a value that keeps following the pins. Directed cases reassert reset while the dividers are high and check the starting state.

// File: rtl/strap_tclk_pkg.sv
// Package: shared constants and types for the strap-latched test-clock block.
// Assumes four shared pins: bit 0 bus mode, bits 3:1 frequency select.
package strap_tclk_pkg;

    localparam int STRAP_W = 4;
    localparam int FSEL_W  = STRAP_W - 1;

    // {fs2, fs1, fs0} value that selects production test
    localparam logic [FSEL_W-1:0] TEST_CODE = 3'b011;

    // Divider counter widths
    localparam int QUAD_W  = 2;
    localparam int TRIP_W  = 2;
    localparam logic [TRIP_W-1:0] TRIP_LAST = 2'd2;

    typedef enum logic [1:0] {
        ROLE_REF = 2'd0,
        ROLE_CPU = 2'd1,
        ROLE_BUS = 2'd2
    } pad_role_e;

    // Clock carried by each shared pin in test mode, index 0 first
    localparam pad_role_e PAD_ROLE [STRAP_W] = '{ROLE_REF, ROLE_CPU, ROLE_CPU, ROLE_BUS};

    typedef struct packed {
        logic              bus_sync;
        logic [FSEL_W-1:0] fsel;
    } strap_t;

endpackage

// File: rtl/strap_latch.sv
// Module: strap_latch
// Captures the shared-pin levels on every reset cycle. The last sample taken
// before reset release stays frozen afterwards. Also produces the pad output
// enable, which rises on the first edge out of reset.
// Assumes por_n is synchronous to clk and that the pins carry defined levels.
module strap_latch
    import strap_tclk_pkg::*;
(
    input  logic               clk,
    input  logic               por_n,
    input  logic [STRAP_W-1:0] pad_in,
    output strap_t             strap_q,
    output logic               drive_en
);

    // Sample the straps while reset is held; hold them afterwards
    always_ff @(posedge clk) begin
        if (!por_n) begin
            strap_q.bus_sync <= pad_in[0];
            strap_q.fsel     <= pad_in[STRAP_W-1:1];
        end
    end

    // Output enable: low in reset, high from the first edge after release
    always_ff @(posedge clk) begin
        if (!por_n) drive_en <= 1'b0;
        else        drive_en <= 1'b1;
    end

endmodule

// File: rtl/tclk_divider.sv
// Module: tclk_divider
// Produces REF/2, REF/4 and REF/3 as register outputs, all low at reset
// release and held low while run is low.
// Assumes run is stable after reset release.
module tclk_divider
    import strap_tclk_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic run,
    output logic div2,
    output logic div4,
    output logic div3
);

    logic [QUAD_W-1:0] quad_cnt;
    logic [TRIP_W-1:0] trip_cnt;
    logic              trip_q;

    // Free-running modulo-4 count; bit 0 gives /2 and bit 1 gives /4
    always_ff @(posedge clk) begin
        if (!por_n || !run) quad_cnt <= '0;
        else                quad_cnt <= quad_cnt + 1'b1;
    end

    // Modulo-3 count for the divide-by-3
    always_ff @(posedge clk) begin
        if (!por_n || !run)          trip_cnt <= '0;
        else if (trip_cnt == TRIP_LAST) trip_cnt <= '0;
        else                         trip_cnt <= trip_cnt + 1'b1;
    end

    // Divide-by-3 output: one period high after each wrap of the count
    always_ff @(posedge clk) begin
        if (!por_n || !run) trip_q <= 1'b0;
        else                trip_q <= (trip_cnt == TRIP_LAST);
    end

    assign div2 = quad_cnt[0];
    assign div4 = quad_cnt[QUAD_W-1];
    assign div3 = trip_q;

endmodule

// File: rtl/shared_pad_mux.sv
// Module: shared_pad_mux
// Chooses, per shared pin, between its test clock (given by PAD_ROLE) and
// the external normal-mode clock.
// Assumes the test clocks are already low outside test mode.
module shared_pad_mux
    import strap_tclk_pkg::*;
(
    input  logic               test_mode,
    input  logic               ref_t,
    input  logic               cpu_t,
    input  logic               bus_t,
    input  logic [STRAP_W-1:0] norm_clk,
    output logic [STRAP_W-1:0] pad_out
);

    for (genvar k = 0; k < STRAP_W; k++) begin : g_pad
        if (PAD_ROLE[k] == ROLE_REF) begin : g_ref
            // Pin carries the reference copy in test
            assign pad_out[k] = test_mode ? ref_t : norm_clk[k];
        end else if (PAD_ROLE[k] == ROLE_CPU) begin : g_cpu
            // Pin carries the CPU test clock in test
            assign pad_out[k] = test_mode ? cpu_t : norm_clk[k];
        end else begin : g_bus
            // Pin carries the bus test clock in test
            assign pad_out[k] = test_mode ? bus_t : norm_clk[k];
        end
    end

endmodule

// File: rtl/strap_tclk_gen.sv
// Module: strap_tclk_gen (top)
// Latches the configuration straps during power-on reset, then turns the
// shared pins into clock outputs. When the test code is latched, it produces
// divided copies of the reference clock.
// Assumes synchronous active-low reset and that the pads supply pull-ups.
module strap_tclk_gen
    import strap_tclk_pkg::*;
#(
    parameter int N_CPU = 8,
    parameter int N_BUS = 6
) (
    input  logic               clk_ref,
    input  logic               por_n,
    input  logic [STRAP_W-1:0] pad_in,
    input  logic [STRAP_W-1:0] norm_pad_clk,
    output logic [STRAP_W-1:0] pad_out,
    output logic [STRAP_W-1:0] pad_oe,
    output logic               o_bus_sync,
    output logic [FSEL_W-1:0]  o_fsel,
    output logic               o_test_mode,
    output logic               o_ref_clk,
    output logic [N_CPU-1:0]   o_cpu_clk,
    output logic [N_BUS-1:0]   o_bus_clk,
    output logic               o_clk48,
    output logic               o_clk24
);

    strap_t strap_q;
    logic   drive_en;
    logic   test_mode;
    logic   div2, div4, div3;
    logic   bus_t;
    logic   ref_t;

    strap_latch u_latch (
        .clk      (clk_ref),
        .por_n    (por_n),
        .pad_in   (pad_in),
        .strap_q  (strap_q),
        .drive_en (drive_en)
    );

    // Test decode on the latched select code
    assign test_mode = (strap_q.fsel == TEST_CODE);

    tclk_divider u_div (
        .clk   (clk_ref),
        .por_n (por_n),
        .run   (test_mode),
        .div2  (div2),
        .div4  (div4),
        .div3  (div3)
    );

    // Bus clock follows the latched bus mode
    assign bus_t = strap_q.bus_sync ? div4 : div3;
    // Reference copy only once the pins are driving
    assign ref_t = clk_ref & test_mode & drive_en;

    for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
        assign o_cpu_clk[c] = div2;
    end

    for (genvar b = 0; b < N_BUS; b++) begin : g_bus
        assign o_bus_clk[b] = bus_t;
    end

    shared_pad_mux u_mux (
        .test_mode (test_mode),
        .ref_t     (ref_t),
        .cpu_t     (div2),
        .bus_t     (bus_t),
        .norm_clk  (norm_pad_clk),
        .pad_out   (pad_out)
    );

    assign pad_oe      = {STRAP_W{drive_en}};
    assign o_bus_sync  = strap_q.bus_sync;
    assign o_fsel      = strap_q.fsel;
    assign o_test_mode = test_mode;
    assign o_ref_clk   = ref_t;
    assign o_clk48     = div2;
    assign o_clk24     = div4;

endmodule

// File: rtl/strap_tclk_chk.sv
// Module: strap_tclk_chk
// Checker with the timing properties of strap_tclk_gen, bound to the top.
module strap_tclk_chk
    import strap_tclk_pkg::*;
#(
    parameter int N_CPU = 8,
    parameter int N_BUS = 6
) (
    input logic               clk_ref,
    input logic               por_n,
    input logic [STRAP_W-1:0] pad_out,
    input logic [STRAP_W-1:0] pad_oe,
    input logic               o_bus_sync,
    input logic [FSEL_W-1:0]  o_fsel,
    input logic               o_test_mode,
    input logic               o_ref_clk,
    input logic [N_CPU-1:0]   o_cpu_clk,
    input logic [N_BUS-1:0]   o_bus_clk,
    input logic               o_clk48,
    input logic               o_clk24
);

    // R2
    code_hold_chk: assert property (@(posedge clk_ref) disable iff (!por_n)
        $past(por_n) |-> $stable({o_bus_sync, o_fsel}));

    // R3
    oe_up_chk: assert property (@(posedge clk_ref) disable iff (!por_n)
        $past(por_n) |-> (pad_oe == '1));

    // R9
    idle_low_chk: assert property (@(posedge clk_ref) disable iff (!por_n)
        !o_test_mode |-> (o_cpu_clk == '0 && o_bus_clk == '0 && !o_clk48 && !o_clk24));

    // R6
    cpu_toggle_chk: assert property (@(posedge clk_ref) disable iff (!por_n)
        (o_test_mode && $past(por_n)) |-> (o_cpu_clk[0] != $past(o_cpu_clk[0])));

    // R6
    cpu_match_chk: assert property (@(posedge clk_ref) disable iff (!por_n)
        (o_cpu_clk == {N_CPU{o_clk48}}) && (o_bus_clk == {N_BUS{o_bus_clk[0]}}));

    // R7
    quarter_phase_chk: assert property (@(posedge clk_ref) disable iff (!por_n)
        $rose(o_clk24) |-> $fell(o_clk48));

    // R8
    third_pulse_chk: assert property (@(posedge clk_ref) disable iff (!por_n)
        (o_test_mode && !o_bus_sync && o_bus_clk[0]) |=> !o_bus_clk[0]);

    // R10
    pad_role_chk: assert property (@(posedge clk_ref) disable iff (!por_n)
        o_test_mode |-> (pad_out[1] == o_cpu_clk[0] && pad_out[2] == o_cpu_clk[0]
                         && pad_out[3] == o_bus_clk[0] && pad_out[0] == o_ref_clk));

endmodule

bind strap_tclk_gen strap_tclk_chk #(.N_CPU(N_CPU), .N_BUS(N_BUS)) u_chk (
    .clk_ref     (clk_ref),
    .por_n       (por_n),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .o_bus_sync  (o_bus_sync),
    .o_fsel      (o_fsel),
    .o_test_mode (o_test_mode),
    .o_ref_clk   (o_ref_clk),
    .o_cpu_clk   (o_cpu_clk),
    .o_bus_clk   (o_bus_clk),
    .o_clk48     (o_clk48),
    .o_clk24     (o_clk24)
);

// File: tb/strap_tclk_gen_tb.sv
module strap_tclk_gen_tb;

    localparam int N_CPU = 8;
    localparam int N_BUS = 6;
    localparam int RUN_EDGES = 12;

    typedef struct packed {
        logic [3:0] strap;
        logic [3:0] norm;
        logic       exp_test;
        logic       exp_sync;
    } vec_t;

    // strap bit 0 = bus mode, bits 3:1 = {fs2,fs1,fs0}; test when fs = 3'b011
    localparam vec_t VECS [7] = '{
        '{4'b0111, 4'b1010, 1'b1, 1'b1},
        '{4'b0110, 4'b0101, 1'b1, 1'b0},
        '{4'b1111, 4'b1100, 1'b0, 1'b1},
        '{4'b0000, 4'b0011, 1'b0, 1'b0},
        '{4'b1110, 4'b1001, 1'b0, 1'b0},
        '{4'b0011, 4'b0110, 1'b0, 1'b1},
        '{4'b0101, 4'b1111, 1'b0, 1'b1}
    };

    logic             clk = 1'b0;
    logic             por_n = 1'b0;
    logic [3:0]       pad_in = 4'b1111;
    logic [3:0]       norm_pad_clk = 4'b0000;
    logic [3:0]       pad_out, pad_oe;
    logic             o_bus_sync, o_test_mode, o_ref_clk, o_clk48, o_clk24;
    logic [2:0]       o_fsel;
    logic [N_CPU-1:0] o_cpu_clk;
    logic [N_BUS-1:0] o_bus_clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    strap_tclk_gen #(.N_CPU(N_CPU), .N_BUS(N_BUS)) u_dut (
        .clk_ref      (clk),
        .por_n        (por_n),
        .pad_in       (pad_in),
        .norm_pad_clk (norm_pad_clk),
        .pad_out      (pad_out),
        .pad_oe       (pad_oe),
        .o_bus_sync   (o_bus_sync),
        .o_fsel       (o_fsel),
        .o_test_mode  (o_test_mode),
        .o_ref_clk    (o_ref_clk),
        .o_cpu_clk    (o_cpu_clk),
        .o_bus_clk    (o_bus_clk),
        .o_clk48      (o_clk48),
        .o_clk24      (o_clk24)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Hold reset with the given straps, release, then invert the pins
    task automatic strap_reset(input logic [3:0] s, input logic [3:0] nrm);
        @(negedge clk);
        por_n = 1'b0;
        pad_in = s;
        norm_pad_clk = nrm;
        repeat (3) @(posedge clk);
        @(negedge clk);
        por_n = 1'b1;
        pad_in = ~s;
        #1;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R11: starting state while reset is held
        pad_in = 4'b0111;
        repeat (2) @(posedge clk);
        #2;
        chk(pad_oe == 4'b0000, "R11", "oe in reset", pad_oe, 0);
        chk(o_cpu_clk == '0 && o_bus_clk == '0 && !o_clk48 && !o_clk24, "R11",
            "dividers in reset", {o_clk48, o_clk24}, 0);
        chk(o_ref_clk == 1'b0, "R11", "ref gated in reset", o_ref_clk, 0);

        foreach (VECS[vi]) begin
            vec_t v;
            v = VECS[vi];
            strap_reset(v.strap, v.norm);
            chk(o_fsel == v.strap[3:1], "R1", "fsel captured", o_fsel, v.strap[3:1]);
            chk(o_bus_sync == v.strap[0], "R1", "bus mode captured", o_bus_sync, v.strap[0]);
            chk(o_test_mode == v.exp_test, "R4", "test decode", o_test_mode, v.exp_test);
            chk(pad_oe == 4'b0000, "R3", "oe at release", pad_oe, 0);
            for (int n = 1; n <= RUN_EDGES; n++) begin
                logic e2, e4, e3, eb;
                logic [3:0] ep;
                @(posedge clk);
                #2;
                e2 = v.exp_test && (n % 2 == 1);
                e4 = v.exp_test && (n % 4 >= 2);
                e3 = v.exp_test && (n % 3 == 0);
                eb = v.exp_sync ? e4 : e3;
                ep = v.exp_test ? {eb, e2, e2, 1'b1} : v.norm;
                chk(o_cpu_clk == {N_CPU{e2}}, "R6", "cpu clocks", o_cpu_clk, {N_CPU{e2}});
                chk(o_clk48 == e2, "R6", "clk48", o_clk48, e2);
                chk(o_clk24 == e4, "R7", "clk24", o_clk24, e4);
                chk(o_bus_clk == {N_BUS{eb}}, "R8", "bus clocks", o_bus_clk, {N_BUS{eb}});
                chk(o_ref_clk == v.exp_test, "R5", "ref high phase", o_ref_clk, v.exp_test);
                chk(pad_oe == 4'b1111, "R3", "oe after release", pad_oe, 4'b1111);
                chk(pad_out == ep, v.exp_test ? "R10" : "R9", "pads", pad_out, ep);
                #5;
                chk(o_ref_clk == 1'b0, "R5", "ref low phase", o_ref_clk, 0);
            end
            chk(o_fsel == v.strap[3:1] && o_bus_sync == v.strap[0], "R2",
                "code held after pin change", {o_fsel, o_bus_sync}, v.strap);
        end

        // R11: reassert reset while the dividers are high, relatch new code
        strap_reset(4'b0111, 4'b0000);
        @(posedge clk);
        @(negedge clk);
        por_n = 1'b0;
        pad_in = 4'b0110;
        @(posedge clk);
        #2;
        chk(o_cpu_clk == '0 && !o_clk48, "R11", "cpu cleared by reset", o_clk48, 0);
        chk(pad_oe == 4'b0000, "R11", "oe cleared by reset", pad_oe, 0);
        chk(o_ref_clk == 1'b0, "R11", "ref gated by reset", o_ref_clk, 0);
        chk(o_bus_sync == 1'b0, "R1", "relatched bus mode", o_bus_sync, 0);
        @(negedge clk);
        por_n = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        chk(o_bus_clk == {N_BUS{1'b1}}, "R8", "third pulse after relatch", o_bus_clk[0], 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule